// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address into a physical address after a translation-buffer miss. It splits the address into a directory index, a table index and a page offset, fetches the directory entry from the directory base plus four times the directory index, then fetches the table entry from the table base held in that directory entry. If both entries are present and permit the access, it reports the physical address; otherwise it stops and reports a fault.

Memory is reached through a request/acknowledge port that carries one read or one write at a time. While walking, the block sets the accessed flag in every entry it uses and the dirty flag in the table entry on a write access. It writes an entry back only when one of those flags actually changes. A fault reports the virtual address, absence versus protection, the level that failed, and the access type and privilege.

Top module: `ptw_walker`

## Requirements
- R1: After reset `req_ready` is 1, `done` and `fault` are 0 and `mem_req` is 0.
- R2: The first read of a walk goes to `dir_base + 4*va[31:22]`.
- R3: The table entry read goes to `{dir_entry[31:12], 12'h000} + 4*va[21:12]`.
- R4: On success `done` pulses for one cycle with `done_paddr = {table_entry[31:12], va[11:0]}`. `done` and `fault` are never high together.
- R5: A directory entry with bit 0 (present) clear ends the walk with `fault`, `fault_prot=0` and `fault_table=0`. No table read follows.
- R6: A table entry with bit 0 clear ends the walk with `fault`, `fault_prot=0` and `fault_table=1`.
- R7: A user access (`req_user=1`) to an entry with bit 2 (user allowed) clear is a protection fault (`fault_prot=1`), at either level. The same access made in supervisor mode succeeds.
- R8: A write access to an entry with bit 1 (writable) clear is a protection fault. A read of the same entry succeeds.
- R9: A successful walk leaves bit 5 (accessed) set in memory in both entries. A faulting entry is not written.
- R10: A write access sets bit 6 (dirty) in the table entry. A read access leaves bit 6 unchanged.
- R11: An entry is written back only when bit 5 or bit 6 changes. A walk whose entries already hold the needed bits issues no write.
- R12: A fault reports the virtual address (`fault_vaddr`), `fault_write` and `fault_user` of the failing request.
- R13: A request is taken only while `req_ready` is 1. A `req_valid` raised during a walk is ignored and starts no memory traffic.
- R14: Once raised, `mem_req` stays high with a steady address, write flag and write data until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_base | input | 32 | Physical base of the page directory, sampled when a request is taken |
| req_valid | input | 1 | Start a walk |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is made in user mode |
| req_ready | output | 1 | Walker idle; a request may be taken |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Pending access is a write |
| mem_addr | output | 32 | Entry address |
| mem_wdata | output | 32 | Entry value written back |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Entry read data |
| done | output | 1 | One-cycle success strobe |
| done_paddr | output | 32 | Translated physical address |
| fault | output | 1 | One-cycle fault strobe |
| fault_vaddr | output | 32 | Virtual address that faulted |
| fault_prot | output | 1 | 1 = protection violation, 0 = entry absent |
| fault_table | output | 1 | 1 = table level, 0 = directory level |
| fault_write | output | 1 | Faulting access was a write |
| fault_user | output | 1 | Faulting access was in user mode |

## Verification
The bench builds the walker with its default split of 10, 10 and 12 address bits, so every index and offset lands on a fixed bit range that the bench computes for itself. Its memory model answers each request after a two-cycle wait. This exposes the hold-until-acknowledge rule and lets a stray request be injected while a read is pending. Walks hit the same entries repeatedly, which reaches the cases where flags are already set and no write-back should follow.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned PA_W     = 32;
  localparam int unsigned ENT_W    = 32;
  localparam int unsigned PG_SHIFT = 12;

  localparam int unsigned B_PRES  = 0;
  localparam int unsigned B_WR    = 1;
  localparam int unsigned B_USR   = 2;
  localparam int unsigned B_ACC   = 5;
  localparam int unsigned B_DIRTY = 6;

  typedef enum logic [2:0] {
    S_IDLE, S_DIR_RD, S_DIR_WB, S_TBL_RD, S_TBL_WB, S_DONE, S_FAULT
  } walk_st_e;

  // base + idx * 4 (entries are 4 bytes)
  function automatic logic [PA_W-1:0] slot_addr(input logic [PA_W-1:0] base,
                                                 input logic [PA_W-1:0] idx);
    return base + (idx << 2);
  endfunction

  // Page-aligned frame base held in the upper entry bits
  function automatic logic [PA_W-1:0] frame_base(input logic [ENT_W-1:0] ent);
    return {ent[ENT_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
  endfunction
endpackage

// File: rtl/ptw_check.sv
module ptw_check
  import ptw_pkg::*;
(
  input  logic [ENT_W-1:0] ent,
  input  logic             is_tbl,
  input  logic             is_wr,
  input  logic             is_usr,
  output logic             absent,
  output logic             prot,
  output logic [ENT_W-1:0] upd,
  output logic             changed
);
  always_comb begin
    absent = !ent[B_PRES];
    prot   = !absent && ((is_usr && !ent[B_USR]) || (is_wr && !ent[B_WR]));
    upd    = ent;
    upd[B_ACC] = 1'b1;
    if (is_tbl && is_wr) upd[B_DIRTY] = 1'b1;
    changed = (upd != ent);
  end

  // R5: an absent entry is never reported as a protection violation
  always_comb begin
    if (absent) p_absent_not_prot_r5: assert (!prot);
  end
endmodule

// File: rtl/ptw_addr.sv
module ptw_addr
  import ptw_pkg::*;
#(
  parameter int unsigned DIR_IDX_W = 10,
  parameter int unsigned TBL_IDX_W = 10,
  parameter int unsigned OFF_W     = 12
) (
  input  logic [PA_W-1:0]                      base,
  input  logic [DIR_IDX_W+TBL_IDX_W+OFF_W-1:0] va,
  input  logic [ENT_W-1:0]                     dir_ent,
  input  logic [ENT_W-1:0]                     tbl_ent,
  output logic [PA_W-1:0]                      dir_addr,
  output logic [PA_W-1:0]                      tbl_addr,
  output logic [PA_W-1:0]                      paddr
);
  localparam int unsigned VA_W = DIR_IDX_W + TBL_IDX_W + OFF_W;

  logic [DIR_IDX_W-1:0] dir_idx;
  logic [TBL_IDX_W-1:0] tbl_idx;
  logic [OFF_W-1:0]     off;

  assign dir_idx  = va[VA_W-1 -: DIR_IDX_W];
  assign tbl_idx  = va[OFF_W +: TBL_IDX_W];
  assign off      = va[OFF_W-1:0];
  assign dir_addr = slot_addr(base, {{(PA_W-DIR_IDX_W){1'b0}}, dir_idx});
  assign tbl_addr = slot_addr(frame_base(dir_ent), {{(PA_W-TBL_IDX_W){1'b0}}, tbl_idx});
  assign paddr    = frame_base(tbl_ent) | {{(PA_W-OFF_W){1'b0}}, off};
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int unsigned DIR_IDX_W = 10,
  parameter int unsigned TBL_IDX_W = 10,
  parameter int unsigned OFF_W     = 12,
  localparam int unsigned VA_W     = DIR_IDX_W + TBL_IDX_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PA_W-1:0]  dir_base,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  input  logic             req_user,
  output logic             req_ready,
  output logic             mem_req,
  output logic             mem_we,
  output logic [PA_W-1:0]  mem_addr,
  output logic [ENT_W-1:0] mem_wdata,
  input  logic             mem_ack,
  input  logic [ENT_W-1:0] mem_rdata,
  output logic             done,
  output logic [PA_W-1:0]  done_paddr,
  output logic             fault,
  output logic [VA_W-1:0]  fault_vaddr,
  output logic             fault_prot,
  output logic             fault_table,
  output logic             fault_write,
  output logic             fault_user
);
  walk_st_e         st;
  logic [VA_W-1:0]  va_q;
  logic [PA_W-1:0]  base_q;
  logic [ENT_W-1:0] dir_q, tbl_q;
  logic             wr_q, usr_q, prot_q, lvl_q;

  logic             chk_absent, chk_prot, chk_changed;
  logic [ENT_W-1:0] chk_upd;
  logic [PA_W-1:0]  dir_addr, tbl_addr, paddr;

  // named events for assertions
  logic rd_ack, wb_ack, entry_bad;
  assign rd_ack    = mem_req && !mem_we && mem_ack;
  assign wb_ack    = mem_req && mem_we && mem_ack;
  assign entry_bad = chk_absent || chk_prot;

  ptw_check u_chk (
    .ent     (mem_rdata),
    .is_tbl  (st == S_TBL_RD),
    .is_wr   (wr_q),
    .is_usr  (usr_q),
    .absent  (chk_absent),
    .prot    (chk_prot),
    .upd     (chk_upd),
    .changed (chk_changed)
  );

  ptw_addr #(.DIR_IDX_W(DIR_IDX_W), .TBL_IDX_W(TBL_IDX_W), .OFF_W(OFF_W)) u_addr (
    .base     (base_q),
    .va       (va_q),
    .dir_ent  (dir_q),
    .tbl_ent  (tbl_q),
    .dir_addr (dir_addr),
    .tbl_addr (tbl_addr),
    .paddr    (paddr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      va_q   <= '0;
      base_q <= '0;
      dir_q  <= '0;
      tbl_q  <= '0;
      wr_q   <= 1'b0;
      usr_q  <= 1'b0;
      prot_q <= 1'b0;
      lvl_q  <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          wr_q   <= req_write;
          usr_q  <= req_user;
          base_q <= dir_base;
          st     <= S_DIR_RD;
        end
        S_DIR_RD: if (mem_ack) begin
          if (entry_bad) begin
            prot_q <= chk_prot;
            lvl_q  <= 1'b0;
            st     <= S_FAULT;
          end else begin
            dir_q <= chk_upd;
            st    <= chk_changed ? S_DIR_WB : S_TBL_RD;
          end
        end
        S_DIR_WB: if (mem_ack) st <= S_TBL_RD;
        S_TBL_RD: if (mem_ack) begin
          if (entry_bad) begin
            prot_q <= chk_prot;
            lvl_q  <= 1'b1;
            st     <= S_FAULT;
          end else begin
            tbl_q <= chk_upd;
            st    <= chk_changed ? S_TBL_WB : S_DONE;
          end
        end
        S_TBL_WB: if (mem_ack) st <= S_DONE;
        default:  st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = (st == S_DIR_RD) || (st == S_DIR_WB) || (st == S_TBL_RD) || (st == S_TBL_WB);
    mem_we    = (st == S_DIR_WB) || (st == S_TBL_WB);
    mem_addr  = ((st == S_TBL_RD) || (st == S_TBL_WB)) ? tbl_addr : dir_addr;
    mem_wdata = (st == S_DIR_WB) ? dir_q : (st == S_TBL_WB) ? tbl_q : '0;
  end

  assign req_ready   = (st == S_IDLE);
  assign done        = (st == S_DONE);
  assign done_paddr  = paddr;
  assign fault       = (st == S_FAULT);
  assign fault_vaddr = va_q;
  assign fault_prot  = prot_q;
  assign fault_table = lvl_q;
  assign fault_write = wr_q;
  assign fault_user  = usr_q;

  // R4: success and fault strobes are exclusive
  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  // R14: a pending request holds address, direction and data until acknowledged
  p_req_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R13: no memory traffic while the walker is ready for a new request
  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req);

  // R9: every write-back carries a present entry with its accessed flag set
  p_wb_accessed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[B_ACC] && mem_wdata[B_PRES]));

  // R12: a fault strobe follows directly on a read acknowledgement
  p_fault_after_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $past(rd_ack));

  // R4: a success strobe follows directly on an acknowledgement
  p_done_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rd_ack || wb_ack));
endmodule

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;
  localparam int LAT = 2;
  localparam logic [31:0] BASE = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] dir_base = BASE;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0, req_user = 1'b0;
  logic        req_ready, mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        done, fault, fault_prot, fault_table, fault_write, fault_user;
  logic [31:0] done_paddr, fault_vaddr;

  always #10 clk = ~clk;

  ptw_walker uut (
    .clk(clk), .rst_n(rst_n), .dir_base(dir_base),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
    .req_ready(req_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(done), .done_paddr(done_paddr), .fault(fault), .fault_vaddr(fault_vaddr),
    .fault_prot(fault_prot), .fault_table(fault_table), .fault_write(fault_write),
    .fault_user(fault_user)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [logic [31:0]];
  int rd_n, wr_n, cnt, hold_err;
  logic [31:0] rd_log [4];
  logic pend;
  logic [31:0] hold_a, hold_d;
  logic hold_we;

  function automatic logic [31:0] rdm(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // memory model: acknowledges after LAT waiting cycles
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; mem_rdata <= '0; cnt = 0; pend = 1'b0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        if (pend && (mem_addr !== hold_a || mem_we !== hold_we || mem_wdata !== hold_d))
          hold_err++;
        pend = 1'b1; hold_a = mem_addr; hold_we = mem_we; hold_d = mem_wdata;
        if (cnt == LAT) begin
          cnt = 0; pend = 1'b0; mem_ack <= 1'b1;
          if (mem_we) begin
            mem[mem_addr] = mem_wdata; wr_n++;
          end else begin
            mem_rdata <= rdm(mem_addr);
            if (rd_n < 4) rd_log[rd_n] = mem_addr;
            rd_n++;
          end
        end else cnt++;
      end
    end
  end

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  logic got_done, got_fault, r_prot, r_tbl, r_w, r_u;
  logic [31:0] r_pa, r_va;

  task automatic walk(input logic [31:0] va, input logic w, input logic u, input bit poke);
    rd_n = 0; wr_n = 0; got_done = 0; got_fault = 0;
    @(negedge clk);
    req_vaddr = va; req_write = w; req_user = u; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (poke && i == 2) begin
        req_valid = 1'b1; req_vaddr = 32'hFFC0_0FFF; req_write = 1'b1; req_user = 1'b1;
      end
      if (poke && i == 3) req_valid = 1'b0;
      if (done || fault) begin
        got_done = done; got_fault = fault; r_pa = done_paddr; r_va = fault_vaddr;
        r_prot = fault_prot; r_tbl = fault_table; r_w = fault_write; r_u = fault_user;
        break;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "ready", req_ready, 1); chk("R1", "done", done, 0);
    chk("R1", "fault", fault, 0);     chk("R1", "mem_req", mem_req, 0);
  endtask

  task automatic t_basic_read();
    walk(32'h0040_3123, 0, 1, 0);
    chk("R2", "dir read addr", rd_log[0], BASE + 32'd4);
    chk("R3", "tbl read addr", rd_log[1], 32'h0002_000C);
    chk("R4", "done", got_done, 1); chk("R4", "fault", got_fault, 0);
    chk("R4", "paddr", r_pa, 32'h0ABC_D123);
    chk("R9", "dir accessed", rdm(BASE + 32'd4), 32'h0002_0027);
    chk("R10", "tbl read no dirty", rdm(32'h0002_000C), 32'h0ABC_D027);
    chk("R11", "two write-backs", wr_n, 2);
  endtask

  task automatic t_repeat_and_write();
    walk(32'h0040_3123, 0, 1, 0);
    chk("R11", "no write-back when set", wr_n, 0);
    chk("R4", "repeat paddr", r_pa, 32'h0ABC_D123);
    walk(32'h0040_3123, 1, 1, 0);
    chk("R10", "dirty set on write", rdm(32'h0002_000C), 32'h0ABC_D067);
    chk("R11", "only table written", wr_n, 1);
    chk("R4", "write done", got_done, 1);
  endtask

  task automatic t_dir_absent();
    walk(32'h0080_0456, 1, 0, 0);
    chk("R5", "fault", got_fault, 1); chk("R5", "level dir", r_tbl, 0);
    chk("R5", "cause absent", r_prot, 0); chk("R5", "single read", rd_n, 1);
    chk("R9", "no write on fault", wr_n, 0);
    chk("R12", "vaddr", r_va, 32'h0080_0456);
    chk("R12", "write", r_w, 1); chk("R12", "user", r_u, 0);
  endtask

  task automatic t_tbl_absent();
    walk(32'h0040_5000, 0, 0, 0);
    chk("R6", "fault", got_fault, 1); chk("R6", "level tbl", r_tbl, 1);
    chk("R6", "cause absent", r_prot, 0); chk("R6", "reads", rd_n, 2);
  endtask

  task automatic t_user_prot();
    walk(32'h0040_6ABC, 0, 1, 0);
    chk("R7", "user fault", got_fault, 1); chk("R7", "prot", r_prot, 1);
    chk("R7", "level tbl", r_tbl, 1);
    chk("R9", "faulting entry untouched", rdm(32'h0002_0018), 32'h0055_5003);
    walk(32'h0040_6ABC, 0, 0, 0);
    chk("R7", "supervisor ok", got_done, 1);
    chk("R7", "supervisor paddr", r_pa, 32'h0055_5ABC);
    walk(32'h00C0_1000, 0, 1, 0);
    chk("R7", "dir user fault", got_fault, 1); chk("R7", "dir prot", r_prot, 1);
    chk("R7", "dir level", r_tbl, 0);
  endtask

  task automatic t_ro_prot();
    walk(32'h0040_7010, 1, 1, 0);
    chk("R8", "write fault", got_fault, 1); chk("R8", "prot", r_prot, 1);
    chk("R12", "write flag", r_w, 1); chk("R12", "user flag", r_u, 1);
    walk(32'h0040_7010, 0, 1, 0);
    chk("R8", "read ok", got_done, 1); chk("R8", "read paddr", r_pa, 32'h0066_6010);
  endtask

  task automatic t_busy_ignore();
    walk(32'h0040_3123, 0, 1, 1);
    chk("R13", "first read addr", rd_log[0], BASE + 32'd4);
    chk("R13", "result kept", r_pa, 32'h0ABC_D123);
    repeat (6) @(negedge clk);
    chk("R13", "no extra reads", rd_n, 2);
    chk("R13", "no extra writes", wr_n, 0);
    chk("R13", "ready", req_ready, 1);
    chk("R14", "request held until ack", hold_err, 0);
  endtask

  initial begin
    hold_err = 0; rd_n = 0; wr_n = 0;
    mem[BASE + 32'd4]    = 32'h0002_0007;
    mem[BASE + 32'd12]   = 32'h0003_0003;
    mem[32'h0002_000C]   = 32'h0ABC_D007;
    mem[32'h0002_0018]   = 32'h0055_5003;
    mem[32'h0002_001C]   = 32'h0066_6005;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_read();
    t_repeat_and_write();
    t_dir_absent();
    t_tbl_absent();
    t_user_prot();
    t_ro_prot();
    t_busy_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule